// File: doc/BRIEF.md
# Prescaled 16-bit Timer with Atomic Byte Access

This block is a 16-bit up-counter with a clock-select prescaler. It sits on an 8-bit register bus. Software picks a division ratio and one of three counting modes. The counter can run free over the full 16-bit range. It can also turn round at compare register A or at a separate capture register. Overflow and two compare events set sticky flags. Each flag raises its interrupt line only when its own enable bit and a global enable input are both high.

The counter, both compare registers and the capture register are 16 bits wide, and each is reached through a low-byte address and a high-byte address. One temporary byte is shared by all of them. It makes multi-byte access atomic:

- To write a register, software writes the high byte first. That write only fills the temporary byte. The low-byte write then commits both bytes in one cycle.
- To read the counter, software reads the low byte first. That read also captures the counter's high byte into the temporary byte, which a later high-byte read returns.

Software that keeps this order always sees a consistent 16-bit value, even while the counter is running.

Top module: `bytebus_timer`

## Requirements
- R1: CTRL (address 0) bits [2:0] select the count rate: code 0 holds the counter; codes 1, 2, 3, 4 and 5 advance it once every 1, 8, 64, 256 and 1024 clocks; codes 6 and 7 also hold it.
- R2: A write to CTRL that changes the select code restarts the prescaler, so the first advance comes a full division period after the write's clock edge.
- R3: In free-running mode (CTRL[4:3] = 00 or 10), the counter wraps from 0xFFFF to 0x0000, and that wrap sets the overflow flag, FLAGS bit 0.
- R4: Whenever the counter takes a new value equal to compare A (addresses 5 low, 6 high), FLAGS bit 1 is set. A match with compare B (addresses 7 low, 8 high) sets FLAGS bit 2. This applies to values reached by counting and to values loaded by a bus write.
- R5: In compare-A mode (CTRL[4:3] = 01), the advance after the counter equals compare A returns it to 0 and sets the overflow flag.
- R6: In capture-top mode (CTRL[4:3] = 11), the capture register (addresses 9 low, 10 high) is the turn-round value in place of compare A.
- R7: A write to the counter low address (3) loads the counter with {temporary byte, written data}. In a cycle where the counter would also advance, the write wins.
- R8: A write to any high-byte address (4, 6, 8, 10) only loads the temporary byte. The 16-bit register itself is unchanged.
- R9: A read of address 3 returns the live low byte and copies the live high byte into the temporary byte. A read of address 4 returns the temporary byte, so reading high before low yields a stale high byte. Compare and capture bytes read back directly.
- R10: Writing 1 to a bit of FLAGS (address 2) clears that flag; writing 0 leaves it as it is. A flag that is set in the same cycle stays set.
- R11: Each interrupt line is high exactly when its flag, its enable bit in IEN (address 1, bits 0 overflow, 1 compare A, 2 compare B) and glob_irq_en are all high.
- R12: An acknowledge pulse clears the matching flag, which drops its interrupt line on the following cycle.
- R13: Synchronous reset clears the counter, the temporary byte, the compare and capture registers, CTRL, IEN and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| bus_rdata | output | 8 | Read data, valid in the same cycle as bus_rd |
| glob_irq_en | input | 1 | Global interrupt enable |
| ack_ovf | input | 1 | Acknowledge for the overflow interrupt |
| ack_cmpa | input | 1 | Acknowledge for the compare A interrupt |
| ack_cmpb | input | 1 | Acknowledge for the compare B interrupt |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmpa | output | 1 | Compare A interrupt request |
| irq_cmpb | output | 1 | Compare B interrupt request |

## Verification
A corrupted temporary byte shows on the bus on the very next high-byte read. It also shows at the next low-byte counter write, which lands a wrong upper half in the counter that a later read exposes. A prescaler phase that is wrong or not restarted moves the first advance by whole clocks, so the tests stop the counter at the exact edge on either side of the expected advance. Flag faults reach the interrupt pins one cycle after the causing edge, when the enables are high.

// File: rtl/bt_pkg.sv
// Package for the byte-bus timer.
// Holds the bus and counter widths, the register address map and the mode encoding.
// Assumes a 16-bit counter seen as two byte lanes.
package bt_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = 2 * DATA_W;
    localparam int PRESC_W = 10;
    localparam int NFLAG   = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 4'd0,
        A_IEN   = 4'd1,
        A_FLAG  = 4'd2,
        A_CNTL  = 4'd3,
        A_CNTH  = 4'd4,
        A_CMPAL = 4'd5,
        A_CMPAH = 4'd6,
        A_CMPBL = 4'd7,
        A_CMPBH = 4'd8,
        A_CAPL  = 4'd9,
        A_CAPH  = 4'd10
    } addr_e;

    typedef enum logic [1:0] {
        M_FREE  = 2'd0,
        M_CMPA  = 2'd1,
        M_FREE2 = 2'd2,
        M_CAP   = 2'd3
    } mode_e;
endpackage

// File: rtl/bt_prescaler.sv
// Clock-select prescaler.
// Emits a one-cycle tick at the rate that the select code picks.
// Assumes that restart is pulsed on the edge where the select code changes.
module bt_prescaler
    import bt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       restart,
    output logic       tick
);
    localparam int LIM_W = PRESC_W + 1;

    logic [PRESC_W-1:0] cnt_q;
    logic [LIM_W-1:0]   lim;

    // Decode the select code into a division ratio; 0 means stopped.
    always_comb begin
        case (sel)
            3'd1:    lim = LIM_W'(1);
            3'd2:    lim = LIM_W'(8);
            3'd3:    lim = LIM_W'(64);
            3'd4:    lim = LIM_W'(256);
            3'd5:    lim = LIM_W'(1024);
            default: lim = '0;
        endcase
    end

    assign tick = (lim != '0) && ({1'b0, cnt_q} == lim - LIM_W'(1));

    // Count clocks within the division period and restart on a select change.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || lim == '0)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + PRESC_W'(1);
    end
endmodule

// File: rtl/bt_counter.sv
// Counter datapath.
// Advances on a tick, turns round at the TOP value of the current mode, accepts bus loads, and reports wrap and compare events.
// Assumes that a bus load has priority over a tick in the same cycle.
module bt_counter
    import bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  mode_e            mode,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [CNT_W-1:0] cap,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_evt,
    output logic             cmpa_evt,
    output logic             cmpb_evt
);
    logic [CNT_W-1:0] cnt_q, nxt, top;
    logic             upd;

    // Pick the turn-round value for the active mode.
    always_comb begin
        case (mode)
            M_CMPA:  top = cmp_a;
            M_CAP:   top = cap;
            default: top = '1;
        endcase
    end

    // Next counter value: a load first, otherwise an advance with wrap at TOP.
    always_comb begin
        nxt     = cnt_q;
        upd     = 1'b0;
        ovf_evt = 1'b0;
        if (load) begin
            nxt = load_val;
            upd = 1'b1;
        end else if (tick) begin
            upd = 1'b1;
            if (cnt_q == top) begin
                nxt     = '0;
                ovf_evt = 1'b1;
            end else begin
                nxt = cnt_q + CNT_W'(1);
            end
        end
    end

    assign cmpa_evt = upd && (nxt == cmp_a);
    assign cmpb_evt = upd && (nxt == cmp_b);
    assign cnt      = cnt_q;

    // Hold the counter state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= nxt;
    end
endmodule

// File: rtl/bytebus_timer.sv
// Top level of the byte-bus timer.
// Decodes the register bus, keeps the control, enable, flag, compare and capture registers, owns the shared temporary byte, and drives the interrupt lines.
// Assumes one bus access per cycle; read side effects take place at the clock edge of the read cycle.
module bytebus_timer
    import bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              glob_irq_en,
    input  logic              ack_ovf,
    input  logic              ack_cmpa,
    input  logic              ack_cmpb,
    output logic              irq_ovf,
    output logic              irq_cmpa,
    output logic              irq_cmpb
);
    logic [4:0]        ctrl_q;
    logic [NFLAG-1:0]  ien_q, flag_q, flag_set, flag_clr, ack_vec;
    logic [DATA_W-1:0] tmp_q;
    logic [CNT_W-1:0]  cmpa_q, cmpb_q, cap_q, cnt_w;
    logic              tick, restart, cnt_load, ovf_evt, cmpa_evt, cmpb_evt;
    logic              wr_ctrl, wr_hi;

    assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
    assign restart  = wr_ctrl && bus_wdata[2:0] != ctrl_q[2:0];
    assign cnt_load = bus_wr && bus_addr == A_CNTL;
    assign wr_hi    = bus_wr && (bus_addr == A_CNTH || bus_addr == A_CMPAH ||
                                 bus_addr == A_CMPBH || bus_addr == A_CAPH);

    bt_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (ctrl_q[2:0]),
        .restart (restart),
        .tick    (tick)
    );

    bt_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (mode_e'(ctrl_q[4:3])),
        .cmp_a    (cmpa_q),
        .cmp_b    (cmpb_q),
        .cap      (cap_q),
        .load     (cnt_load),
        .load_val ({tmp_q, bus_wdata}),
        .cnt      (cnt_w),
        .ovf_evt  (ovf_evt),
        .cmpa_evt (cmpa_evt),
        .cmpb_evt (cmpb_evt)
    );

    // Control, enable, compare and capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ien_q  <= '0;
            cmpa_q <= '0;
            cmpb_q <= '0;
            cap_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  ctrl_q <= bus_wdata[4:0];
                A_IEN:   ien_q  <= bus_wdata[NFLAG-1:0];
                A_CMPAL: cmpa_q <= {tmp_q, bus_wdata};
                A_CMPBL: cmpb_q <= {tmp_q, bus_wdata};
                A_CAPL:  cap_q  <= {tmp_q, bus_wdata};
                default: ;
            endcase
        end
    end

    // Shared temporary byte: loaded by high-byte writes and by counter low-byte reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmp_q <= '0;
        else if (wr_hi)
            tmp_q <= bus_wdata;
        else if (bus_rd && bus_addr == A_CNTL)
            tmp_q <= cnt_w[CNT_W-1:DATA_W];
    end

    assign flag_set = {cmpb_evt, cmpa_evt, ovf_evt};
    assign ack_vec  = {ack_cmpb, ack_cmpa, ack_ovf};
    assign flag_clr = ack_vec | ((bus_wr && bus_addr == A_FLAG) ? bus_wdata[NFLAG-1:0] : '0);

    // Sticky flags: a new event outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else
            flag_q <= (flag_q & ~flag_clr) | flag_set;
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
                A_IEN:   bus_rdata = DATA_W'(ien_q);
                A_FLAG:  bus_rdata = DATA_W'(flag_q);
                A_CNTL:  bus_rdata = cnt_w[DATA_W-1:0];
                A_CNTH:  bus_rdata = tmp_q;
                A_CMPAL: bus_rdata = cmpa_q[DATA_W-1:0];
                A_CMPAH: bus_rdata = cmpa_q[CNT_W-1:DATA_W];
                A_CMPBL: bus_rdata = cmpb_q[DATA_W-1:0];
                A_CMPBH: bus_rdata = cmpb_q[CNT_W-1:DATA_W];
                A_CAPL:  bus_rdata = cap_q[DATA_W-1:0];
                A_CAPH:  bus_rdata = cap_q[CNT_W-1:DATA_W];
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq_ovf  = glob_irq_en && ien_q[0] && flag_q[0];
    assign irq_cmpa = glob_irq_en && ien_q[1] && flag_q[1];
    assign irq_cmpb = glob_irq_en && ien_q[2] && flag_q[2];
endmodule

// File: rtl/bt_checker.sv
// Property checker for bytebus_timer, attached by bind.
// Watches the bus, the select code, the counter, the temporary byte and the flags.
module bt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       glob_irq_en,
    input logic       ack_ovf,
    input logic       ack_cmpa,
    input logic       ack_cmpb,
    input logic       irq_ovf,
    input logic       irq_cmpa,
    input logic       irq_cmpb,
    input logic [2:0] sel,
    input logic [15:0] cnt,
    input logic [7:0] tmp,
    input logic [2:0] flags
);
    // R11: no interrupt line without the global enable.
    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ovf || irq_cmpa || irq_cmpb) |-> glob_irq_en);

    // R1: a stopped select code with no load keeps the counter still.
    assert_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == 3'd0 || sel >= 3'd6) && !(bus_wr && bus_addr == 4'd3)) |=> $stable(cnt));

    // R7: a low-byte counter write lands {temporary byte, data}.
    assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd3) |=> (cnt == {$past(tmp), $past(bus_wdata)}));

    // R8: a high-byte write alone never moves a stopped counter.
    assert_hi_only_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd4 && sel == 3'd0) |=> $stable(cnt));

    // R10: writing zeros to the flag register clears nothing.
    assert_zero_write_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd2 && bus_wdata[2:0] == 3'b000 && !ack_ovf && !ack_cmpa && !ack_cmpb)
        |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind bytebus_timer bt_checker u_bt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .glob_irq_en (glob_irq_en),
    .ack_ovf     (ack_ovf),
    .ack_cmpa    (ack_cmpa),
    .ack_cmpb    (ack_cmpb),
    .irq_ovf     (irq_ovf),
    .irq_cmpa    (irq_cmpa),
    .irq_cmpb    (irq_cmpb),
    .sel         (ctrl_q[2:0]),
    .cnt         (cnt_w),
    .tmp         (tmp_q),
    .flags       (flag_q)
);

// File: tb/bytebus_timer_test.sv
// Bench for bytebus_timer: a table of byte accesses, then directed tests.
module bytebus_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       glob_irq_en = 1'b0;
    logic       ack_ovf = 1'b0, ack_cmpa = 1'b0, ack_cmpb = 1'b0;
    logic       irq_ovf, irq_cmpa, irq_cmpb;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [3:0] CTRL = 4'd0, IEN = 4'd1, FLAG = 4'd2, CNTL = 4'd3, CNTH = 4'd4;
    localparam logic [3:0] CMPAL = 4'd5, CMPAH = 4'd6, CMPBL = 4'd7, CMPBH = 4'd8, CAPL = 4'd9, CAPH = 4'd10;

    // {is_read, address, data or expected}
    localparam int NVEC = 20;
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, CNTH,  8'h12}, {1'b0, CNTL,  8'h34}, {1'b1, CNTL,  8'h34}, {1'b1, CNTH,  8'h12},
        {1'b0, CNTL,  8'h22}, {1'b0, CNTH,  8'h55}, {1'b1, CNTL,  8'h22}, {1'b1, CNTH,  8'h12},
        {1'b0, CMPAH, 8'h10}, {1'b0, CMPAL, 8'hEF}, {1'b1, CMPAL, 8'hEF}, {1'b1, CMPAH, 8'h10},
        {1'b0, CMPBH, 8'h30}, {1'b0, CMPBL, 8'h00}, {1'b1, CMPBL, 8'h00}, {1'b1, CMPBH, 8'h30},
        {1'b0, CAPH,  8'h00}, {1'b0, CAPL,  8'h05}, {1'b1, CAPL,  8'h05}, {1'b1, CAPH,  8'h00}
    };

    bytebus_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .glob_irq_en(glob_irq_en),
        .ack_ovf(ack_ovf), .ack_cmpa(ack_cmpa), .ack_cmpb(ack_cmpb),
        .irq_ovf(irq_ovf), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Every access task starts and ends at a falling edge.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic setcnt(input logic [15:0] v);
        wr(CNTH, v[15:8]);
        wr(CNTL, v[7:0]);
    endtask

    task automatic getcnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(CNTL, lo);
        rd(CNTH, hi);
        v = {hi, lo};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: state after reset
        getcnt(v);   check("R13 counter after reset", v, 16'h0000);
        rd(FLAG, b); check("R13 flags after reset", {8'h0, b}, 16'h0000);
        check("R13 irq lines after reset", {13'h0, irq_ovf, irq_cmpa, irq_cmpb}, 16'h0000);

        // R7 R8 R9: latched byte access table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][12]) begin
                rd(VEC[i][11:8], b);
                check($sformatf("R7/R8/R9 table step %0d", i), {8'h0, b}, {8'h0, VEC[i][7:0]});
            end else begin
                wr(VEC[i][11:8], VEC[i][7:0]);
            end
        end

        // R1: divide by 1, ten advances
        setcnt(16'h0000);
        wr(CTRL, 8'h01); repeat (9) @(negedge clk); wr(CTRL, 8'h00);
        getcnt(v); check("R1 divide-by-1 count", v, 16'h000A);

        // R1 R2: divide by 64, one edge short and then exactly on the period
        setcnt(16'h0000);
        wr(CTRL, 8'h03); repeat (62) @(negedge clk); wr(CTRL, 8'h00);
        getcnt(v); check("R1 divide-by-64 before period", v, 16'h0000);
        wr(CTRL, 8'h03); repeat (63) @(negedge clk); wr(CTRL, 8'h00);
        getcnt(v); check("R1 divide-by-64 at period", v, 16'h0001);

        // R2: a select change restarts the prescaler phase
        wr(CTRL, 8'h03); repeat (40) @(negedge clk); wr(CTRL, 8'h02);
        repeat (7) @(negedge clk); wr(CTRL, 8'h00);
        getcnt(v); check("R2 restart on select change", v, 16'h0002);

        // R3: wrap from 0xFFFF
        wr(FLAG, 8'h07);
        setcnt(16'hFFFF);
        wr(CTRL, 8'h01); wr(CTRL, 8'h00);
        getcnt(v);   check("R3 wrap value", v, 16'h0000);
        rd(FLAG, b); check("R3 overflow flag", {8'h0, b}, 16'h0001);

        // R10: write-one-to-clear
        wr(FLAG, 8'h00); rd(FLAG, b); check("R10 zero write keeps flag", {8'h0, b}, 16'h0001);
        wr(FLAG, 8'h01); rd(FLAG, b); check("R10 one write clears flag", {8'h0, b}, 16'h0000);

        // R4: compare matches by counting and by loading
        setcnt(16'h10EE); wr(CTRL, 8'h01); wr(CTRL, 8'h00);
        rd(FLAG, b); check("R4 compare A by count", {8'h0, b}, 16'h0002);
        wr(FLAG, 8'h07);
        setcnt(16'h2FFF); wr(CTRL, 8'h01); wr(CTRL, 8'h00);
        rd(FLAG, b); check("R4 compare B by count", {8'h0, b}, 16'h0004);
        wr(FLAG, 8'h07);
        setcnt(16'h10EF);
        rd(FLAG, b); check("R4 compare A by load", {8'h0, b}, 16'h0002);
        wr(FLAG, 8'h07);

        // R5: turn round at compare A
        setcnt(16'h10EE);
        wr(CTRL, 8'h09); repeat (1) @(negedge clk); wr(CTRL, 8'h08);
        getcnt(v);   check("R5 counter after compare-A turn", v, 16'h0000);
        rd(FLAG, b); check("R5 flags after compare-A turn", {8'h0, b}, 16'h0003);
        wr(FLAG, 8'h07);

        // R6: turn round at the capture register (0x0005)
        wr(CTRL, 8'h18);
        setcnt(16'h0004);
        wr(CTRL, 8'h19); repeat (1) @(negedge clk); wr(CTRL, 8'h18);
        getcnt(v);   check("R6 counter after capture turn", v, 16'h0000);
        rd(FLAG, b); check("R6 flags after capture turn", {8'h0, b}, 16'h0001);
        wr(FLAG, 8'h07);
        wr(CTRL, 8'h00);

        // R7: a load beats a running count; R8: the high write alone changes nothing
        setcnt(16'h0100);
        wr(CTRL, 8'h01); wr(CNTH, 8'h40); wr(CNTL, 8'h00); wr(CTRL, 8'h00);
        getcnt(v); check("R7 load priority over count", v, 16'h4001);

        // R9: high read before low read returns the stale byte
        setcnt(16'h00FF);
        rd(CNTL, b);
        wr(CTRL, 8'h01); wr(CTRL, 8'h00);
        rd(CNTH, b); check("R9 stale high byte", {8'h0, b}, 16'h0000);
        rd(CNTL, b); check("R9 live low byte", {8'h0, b}, 16'h0000);
        rd(CNTH, b); check("R9 fresh high byte", {8'h0, b}, 16'h0001);

        // R11 R12: interrupt gating and acknowledge
        wr(FLAG, 8'h07);
        wr(IEN, 8'h01);
        setcnt(16'hFFFF); wr(CTRL, 8'h01); wr(CTRL, 8'h00);
        #1 check("R11 irq held by global enable", {15'h0, irq_ovf}, 16'h0000);
        glob_irq_en = 1'b1;
        #1 check("R11 irq raised", {14'h0, irq_ovf, irq_cmpa}, 16'h0002);
        @(negedge clk);
        wr(IEN, 8'h00);
        #1 check("R11 irq masked by enable bit", {15'h0, irq_ovf}, 16'h0000);
        @(negedge clk);
        wr(IEN, 8'h01);
        ack_ovf = 1'b1;
        @(negedge clk);
        ack_ovf = 1'b0;
        #1 check("R12 acknowledge drops irq", {15'h0, irq_ovf}, 16'h0000);
        @(negedge clk);
        rd(FLAG, b); check("R12 acknowledge clears flag", {8'h0, b}, 16'h0000);

        // R13: reset in the middle of a run
        setcnt(16'h1234); wr(CTRL, 8'h01);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        repeat (5) @(negedge clk);
        getcnt(v);    check("R13 counter cleared and stopped", v, 16'h0000);
        rd(CMPAL, b); check("R13 compare A cleared", {8'h0, b}, 16'h0000);
        rd(CTRL, b);  check("R13 control cleared", {8'h0, b}, 16'h0000);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule